// File: doc/BRIEF.md
# Repeated Block Address Generator

This block produces the source and destination start address of every single or burst transfer of a DMA channel that walks memory in two dimensions. A block is a programmed number of bytes split into bursts of `burst_beats` beats of `1 << width_sel` bytes each. The final burst of a block may be shorter when the block size is not a multiple of the burst size. Between two bursts of the same block, each side may jump by a signed burst gap. Between two blocks, each side may jump by a signed block gap. Each gap is measured from the byte just past the previous transfer. The whole block is issued `rpt_m1 + 1` times.

A channel controller pulses `start` with the configuration on the inputs. The block captures the configuration at that edge. It then presents one burst at a time on `burst_vld`, `src_addr`, `dst_addr` and `burst_bytes`. The controller acknowledges each burst with `acc`. One cycle after each acknowledge, the block flags the end of a burst, the end of a block and the end of the whole sequence. No bus signalling is done here.

Top module: `rpt_blk_addr_gen`

## Requirements
- R1: After reset, `burst_vld`, `end_burst`, `end_block`, `end_all` and `cfg_err` are all low.
- R2: A `start` with a valid configuration while idle raises `burst_vld` on the next cycle, with `src_addr` and `dst_addr` equal to the two base addresses.
- R3: `burst_bytes` is the smaller of the bytes left in the current block and `burst_beats << width_sel`. It is never zero while `burst_vld` is high.
- R4: After an accepted burst that is not the last of its block, each side's next address is its previous address plus `burst_bytes` plus that side's sign-extended burst gap. The two sides use independent gaps.
- R5: After the last burst of a block, each side's next address is its previous address plus `burst_bytes` plus that side's sign-extended block gap. The burst gap is not added.
- R6: Exactly `rpt_m1 + 1` blocks are issued, where `rpt_m1` is an 11-bit value, so from 1 to 2048 blocks.
- R7: One cycle after every accepted burst, `end_burst` pulses. `end_block` pulses with it for the last burst of a block. `end_all` pulses with both for the last burst of the last block, and in that same cycle `burst_vld` is low.
- R8: A `start` is refused, and `cfg_err` goes high while `burst_vld` stays low, when any of the following holds:
  - a burst gap equals -8192, the most negative 14-bit code;
  - a block gap equals -65536, the most negative 17-bit code;
  - `blk_bytes` is zero;
  - `burst_beats` is zero.
  
  A later valid `start` clears `cfg_err`.
- R9: `start` is ignored while a sequence runs. The configuration inputs are read only at an accepted `start`.
- R10: While `burst_vld` is high and `acc` is low, the addresses and `burst_bytes` hold their values and no end pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture the configuration and begin a sequence |
| src_base | input | ADDR_W | Source start address |
| dst_base | input | ADDR_W | Destination start address |
| blk_bytes | input | BLK_W | Bytes per block |
| burst_beats | input | BEAT_W | Beats per burst |
| width_sel | input | 2 | Beat size is 1 << width_sel bytes |
| src_burst_ofs | input | BOFS_W | Signed source gap between bursts |
| dst_burst_ofs | input | BOFS_W | Signed destination gap between bursts |
| src_blk_ofs | input | KOFS_W | Signed source gap between blocks |
| dst_blk_ofs | input | KOFS_W | Signed destination gap between blocks |
| rpt_m1 | input | RPT_W | Number of blocks minus one |
| acc | input | 1 | Current burst accepted |
| burst_vld | output | 1 | A burst is being presented |
| src_addr | output | ADDR_W | Source address of the current burst |
| dst_addr | output | ADDR_W | Destination address of the current burst |
| burst_bytes | output | BLK_W | Byte length of the current burst |
| end_burst | output | 1 | A burst was accepted on the previous edge |
| end_block | output | 1 | That burst closed a block |
| end_all | output | 1 | That burst closed the last block |
| cfg_err | output | 1 | The last start was refused |

## Verification
Several properties are checked on every cycle:
- the ordering of the three end pulses and their tie to a preceding acknowledge;
- the bounds on `burst_bytes`;
- address hold while unacknowledged;
- idling while `cfg_err` is high.

The exact address arithmetic needs the bench's sweep over data widths, burst lengths, block sizes, repeat counts, gap values and acknowledge gaps. That includes negative gaps, extreme gaps and a 2048-block run. Only the bench's scenarios can show that the gap arithmetic is right, that short final bursts are handled, that the repeat count is exact, and that a `start` during a run is ignored.

// File: rtl/rbag_pkg.sv
package rbag_pkg;
  localparam int DEF_ADDR_W = 32;
  localparam int DEF_BLK_W  = 16;
  localparam int DEF_BEAT_W = 8;
  localparam int DEF_BOFS_W = 14;
  localparam int DEF_KOFS_W = 17;
  localparam int DEF_RPT_W  = 11;
  localparam int SIDES      = 2;
  localparam int SIDE_SRC   = 0;
  localparam int SIDE_DST   = 1;
endpackage

// File: rtl/rbag_cfg_check.sv
module rbag_cfg_check #(
  parameter int BLK_W  = 16,
  parameter int BEAT_W = 8,
  parameter int BOFS_W = 14,
  parameter int KOFS_W = 17
) (
  input  logic [BLK_W-1:0]  blk_bytes,
  input  logic [BEAT_W-1:0] burst_beats,
  input  logic [BOFS_W-1:0] src_burst_ofs,
  input  logic [BOFS_W-1:0] dst_burst_ofs,
  input  logic [KOFS_W-1:0] src_blk_ofs,
  input  logic [KOFS_W-1:0] dst_blk_ofs,
  output logic              cfg_ok
);
  localparam logic [BOFS_W-1:0] BOFS_MIN = {1'b1, {(BOFS_W-1){1'b0}}};
  localparam logic [KOFS_W-1:0] KOFS_MIN = {1'b1, {(KOFS_W-1){1'b0}}};

  always_comb begin
    cfg_ok = (blk_bytes != '0) && (burst_beats != '0) &&
             (src_burst_ofs != BOFS_MIN) && (dst_burst_ofs != BOFS_MIN) &&
             (src_blk_ofs != KOFS_MIN) && (dst_blk_ofs != KOFS_MIN);
  end
endmodule

// File: rtl/rbag_seq.sv
module rbag_seq #(
  parameter int BLK_W  = 16,
  parameter int BEAT_W = 8,
  parameter int RPT_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              cfg_ok,
  input  logic [BLK_W-1:0]  blk_bytes,
  input  logic [BEAT_W-1:0] burst_beats,
  input  logic [1:0]        width_sel,
  input  logic [RPT_W-1:0]  rpt_m1,
  input  logic              acc,
  output logic              load,
  output logic              step,
  output logic              last,
  output logic              burst_vld,
  output logic [BLK_W-1:0]  burst_bytes,
  output logic              end_burst,
  output logic              end_block,
  output logic              end_all,
  output logic              cfg_err
);
  logic [BLK_W-1:0] blk_r, bb_r, rem_r;
  logic [RPT_W-1:0] rpt_r;
  logic [BLK_W-1:0] bb_in, first_len, reload_len, rem_after, next_len;

  always_comb begin
    bb_in      = BLK_W'(burst_beats) << width_sel;
    first_len  = (blk_bytes < bb_in) ? blk_bytes : bb_in;
    reload_len = (blk_r < bb_r) ? blk_r : bb_r;
    rem_after  = rem_r - burst_bytes;
    next_len   = (rem_after < bb_r) ? rem_after : bb_r;
    last       = (rem_r <= bb_r);
    load       = start && !burst_vld && cfg_ok;
    step       = burst_vld && acc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      burst_vld   <= 1'b0;
      blk_r       <= '0;
      bb_r        <= '0;
      rem_r       <= '0;
      rpt_r       <= '0;
      burst_bytes <= '0;
      end_burst   <= 1'b0;
      end_block   <= 1'b0;
      end_all     <= 1'b0;
      cfg_err     <= 1'b0;
    end else begin
      end_burst <= 1'b0;
      end_block <= 1'b0;
      end_all   <= 1'b0;
      if (start && !burst_vld) begin
        cfg_err <= !cfg_ok;
        if (cfg_ok) begin
          burst_vld   <= 1'b1;
          blk_r       <= blk_bytes;
          bb_r        <= bb_in;
          rem_r       <= blk_bytes;
          rpt_r       <= rpt_m1;
          burst_bytes <= first_len;
        end
      end else if (step) begin
        end_burst <= 1'b1;
        if (last) begin
          end_block <= 1'b1;
          if (rpt_r == '0) begin
            end_all   <= 1'b1;
            burst_vld <= 1'b0;
          end else begin
            rpt_r       <= rpt_r - 1'b1;
            rem_r       <= blk_r;
            burst_bytes <= reload_len;
          end
        end else begin
          rem_r       <= rem_after;
          burst_bytes <= next_len;
        end
      end
    end
  end

  a_r3_len_bound: assert property (@(posedge clk) disable iff (rst)
    burst_vld |-> (burst_bytes != '0) && (burst_bytes <= bb_r) && (burst_bytes <= rem_r));

  a_r7_after_accept: assert property (@(posedge clk) disable iff (rst)
    end_burst |-> $past(step));

  a_r7_all_nested: assert property (@(posedge clk) disable iff (rst)
    end_all |-> end_block && end_burst && !burst_vld);

  a_r7_block_nested: assert property (@(posedge clk) disable iff (rst)
    end_block |-> end_burst);

  a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !burst_vld);
endmodule

// File: rtl/rbag_lane.sv
module rbag_lane #(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 16,
  parameter int BOFS_W = 14,
  parameter int KOFS_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              last,
  input  logic [BLK_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic [BOFS_W-1:0] bofs_in,
  input  logic [KOFS_W-1:0] kofs_in,
  output logic [ADDR_W-1:0] addr
);
  logic [BOFS_W-1:0] bofs_r;
  logic [KOFS_W-1:0] kofs_r;
  logic [ADDR_W-1:0] gap, end_addr;

  always_comb begin
    end_addr = addr + ADDR_W'(len);
    if (last) gap = {{(ADDR_W-KOFS_W){kofs_r[KOFS_W-1]}}, kofs_r};
    else      gap = {{(ADDR_W-BOFS_W){bofs_r[BOFS_W-1]}}, bofs_r};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      bofs_r <= '0;
      kofs_r <= '0;
    end else if (load) begin
      addr   <= base;
      bofs_r <= bofs_in;
      kofs_r <= kofs_in;
    end else if (step) begin
      addr <= end_addr + gap;
    end
  end
endmodule

// File: rtl/rpt_blk_addr_gen.sv
module rpt_blk_addr_gen
  import rbag_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BLK_W  = DEF_BLK_W,
  parameter int BEAT_W = DEF_BEAT_W,
  parameter int BOFS_W = DEF_BOFS_W,
  parameter int KOFS_W = DEF_KOFS_W,
  parameter int RPT_W  = DEF_RPT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [BLK_W-1:0]  blk_bytes,
  input  logic [BEAT_W-1:0] burst_beats,
  input  logic [1:0]        width_sel,
  input  logic [BOFS_W-1:0] src_burst_ofs,
  input  logic [BOFS_W-1:0] dst_burst_ofs,
  input  logic [KOFS_W-1:0] src_blk_ofs,
  input  logic [KOFS_W-1:0] dst_blk_ofs,
  input  logic [RPT_W-1:0]  rpt_m1,
  input  logic              acc,
  output logic              burst_vld,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [BLK_W-1:0]  burst_bytes,
  output logic              end_burst,
  output logic              end_block,
  output logic              end_all,
  output logic              cfg_err
);
  logic cfg_ok, load, step, last;
  logic [SIDES-1:0][ADDR_W-1:0] base_v, addr_v;
  logic [SIDES-1:0][BOFS_W-1:0] bofs_v;
  logic [SIDES-1:0][KOFS_W-1:0] kofs_v;

  assign base_v[SIDE_SRC] = src_base;
  assign base_v[SIDE_DST] = dst_base;
  assign bofs_v[SIDE_SRC] = src_burst_ofs;
  assign bofs_v[SIDE_DST] = dst_burst_ofs;
  assign kofs_v[SIDE_SRC] = src_blk_ofs;
  assign kofs_v[SIDE_DST] = dst_blk_ofs;
  assign src_addr = addr_v[SIDE_SRC];
  assign dst_addr = addr_v[SIDE_DST];

  rbag_cfg_check #(.BLK_W(BLK_W), .BEAT_W(BEAT_W), .BOFS_W(BOFS_W), .KOFS_W(KOFS_W)) u_chk (
    .blk_bytes(blk_bytes), .burst_beats(burst_beats),
    .src_burst_ofs(src_burst_ofs), .dst_burst_ofs(dst_burst_ofs),
    .src_blk_ofs(src_blk_ofs), .dst_blk_ofs(dst_blk_ofs), .cfg_ok(cfg_ok));

  rbag_seq #(.BLK_W(BLK_W), .BEAT_W(BEAT_W), .RPT_W(RPT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start), .cfg_ok(cfg_ok),
    .blk_bytes(blk_bytes), .burst_beats(burst_beats), .width_sel(width_sel),
    .rpt_m1(rpt_m1), .acc(acc), .load(load), .step(step), .last(last),
    .burst_vld(burst_vld), .burst_bytes(burst_bytes), .end_burst(end_burst),
    .end_block(end_block), .end_all(end_all), .cfg_err(cfg_err));

  for (genvar g = 0; g < SIDES; g++) begin : g_lane
    rbag_lane #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .BOFS_W(BOFS_W), .KOFS_W(KOFS_W)) u_lane (
      .clk(clk), .rst(rst), .load(load), .step(step), .last(last),
      .len(burst_bytes), .base(base_v[g]), .bofs_in(bofs_v[g]),
      .kofs_in(kofs_v[g]), .addr(addr_v[g]));
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    burst_vld && !acc && !start |=> burst_vld && $stable(src_addr) && $stable(dst_addr)
                                  && $stable(burst_bytes) && !end_burst);

  a_r2_first_addr: assert property (@(posedge clk) disable iff (rst)
    start && !burst_vld && cfg_ok |=> burst_vld && !cfg_err);
endmodule

// File: tb/rpt_blk_addr_gen_test.sv
module rpt_blk_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, acc = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [15:0] blk_bytes = '0;
  logic [7:0]  burst_beats = '0;
  logic [1:0]  width_sel = '0;
  logic [13:0] src_burst_ofs = '0, dst_burst_ofs = '0;
  logic [16:0] src_blk_ofs = '0, dst_blk_ofs = '0;
  logic [10:0] rpt_m1 = '0;
  logic        burst_vld, end_burst, end_block, end_all, cfg_err;
  logic [31:0] src_addr, dst_addr;
  logic [15:0] burst_bytes;
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpt_blk_addr_gen uut (
    .clk(clk), .rst(rst), .start(start), .src_base(src_base), .dst_base(dst_base),
    .blk_bytes(blk_bytes), .burst_beats(burst_beats), .width_sel(width_sel),
    .src_burst_ofs(src_burst_ofs), .dst_burst_ofs(dst_burst_ofs),
    .src_blk_ofs(src_blk_ofs), .dst_blk_ofs(dst_blk_ofs), .rpt_m1(rpt_m1), .acc(acc),
    .burst_vld(burst_vld), .src_addr(src_addr), .dst_addr(dst_addr),
    .burst_bytes(burst_bytes), .end_burst(end_burst), .end_block(end_block),
    .end_all(end_all), .cfg_err(cfg_err));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_case(input int blk, input int beats, input int wsel, input int rpt,
                          input int sb, input int db, input int sk, input int dk, input int gapsel);
    logic [31:0] es, ed;
    int rem, len, bb, idx;
    bit lst, all;
    es = 32'h1000_0F00 + 32'(gapsel * 64);
    ed = 32'h2000_0000 - 32'(blk);
    bb = beats << wsel;
    @(negedge clk);
    src_base = es; dst_base = ed; blk_bytes = 16'(blk); burst_beats = 8'(beats);
    width_sel = 2'(wsel); rpt_m1 = 11'(rpt);
    src_burst_ofs = 14'(sb); dst_burst_ofs = 14'(db);
    src_blk_ofs = 17'(sk); dst_blk_ofs = 17'(dk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R9: configuration inputs are scrambled after the start edge
    src_base = ~es; dst_base = ~ed; blk_bytes = 16'd3; burst_beats = 8'd1;
    src_burst_ofs = 14'd5; src_blk_ofs = 17'd9; rpt_m1 = 11'd5;
    chk(cfg_err == 1'b0, "R8 cleared by valid start", 96'(cfg_err), 96'(0));
    idx = 0;
    for (int r = 0; r <= rpt; r++) begin
      rem = blk;
      while (rem > 0) begin
        len = (rem < bb) ? rem : bb;
        lst = (rem <= bb);
        all = lst && (r == rpt);
        if (((idx + gapsel) % 3) == 0) begin
          acc = 1'b0;
          @(negedge clk);
          chk(burst_vld && !end_burst && src_addr == es && dst_addr == ed && burst_bytes == 16'(len),
              "R10 hold without accept", {src_addr, dst_addr, burst_bytes, 16'(end_burst)},
              {es, ed, 16'(len), 16'd0});
        end
        chk(burst_vld && src_addr == es && dst_addr == ed && burst_bytes == 16'(len),
            (idx == 0) ? "R2 first burst" : "R3 R4 R5 burst address/length",
            {src_addr, dst_addr, burst_bytes, 16'(burst_vld)}, {es, ed, 16'(len), 16'd1});
        acc = 1'b1;
        if (idx == 1) start = 1'b1;   // R9: start during a run
        @(negedge clk);
        acc = 1'b0; start = 1'b0;
        chk({end_burst, end_block, end_all} == {1'b1, lst, all}, "R7 end pulses",
            96'({end_burst, end_block, end_all}), 96'({1'b1, lst, all}));
        es = es + 32'(len) + (lst ? 32'(sk) : 32'(sb));
        ed = ed + 32'(len) + (lst ? 32'(dk) : 32'(db));
        rem = rem - len;
        idx++;
      end
    end
    chk(!burst_vld, "R6 sequence ends after rpt_m1+1 blocks", 96'(burst_vld), 96'(0));
    @(negedge clk);
    chk(!burst_vld && !end_burst, "R6 R9 stays idle", 96'({burst_vld, end_burst}), 96'(0));
  endtask

  task automatic run_err(input int blk, input int beats, input int sb, input int dk);
    @(negedge clk);
    src_base = 32'h55; dst_base = 32'h66; blk_bytes = 16'(blk); burst_beats = 8'(beats);
    width_sel = 2'd0; rpt_m1 = 11'd0; src_burst_ofs = 14'(sb); dst_burst_ofs = 14'd0;
    src_blk_ofs = 17'd0; dst_blk_ofs = 17'(dk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0; acc = 1'b1;
    chk(cfg_err && !burst_vld, "R8 refused start", 96'({cfg_err, burst_vld}), 96'(2'b10));
    @(negedge clk);
    acc = 1'b0;
    chk(cfg_err && !burst_vld && !end_burst, "R8 no run after refusal",
        96'({cfg_err, burst_vld, end_burst}), 96'(3'b100));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({burst_vld, end_burst, end_block, end_all, cfg_err} == 5'b0, "R1 reset state",
        96'({burst_vld, end_burst, end_block, end_all, cfg_err}), 96'(0));
    for (int w = 0; w < 3; w++)
      for (int b = 1; b <= 3; b++)
        for (int k = 0; k < 3; k++)
          for (int r = 0; r < 3; r++) begin
            int blk, sel;
            blk = (k == 0) ? 8 : (k == 1) ? 12 : 20;
            blk = blk << w;
            sel = (w + b + k + r) % 4;
            case (sel)
              0: run_case(blk, b, w, r, 0, 0, 0, 0, r);
              1: run_case(blk, b, w, r, 4, -8, 100, -300, r);
              2: run_case(blk, b, w, r, -3, 16, -65535, 65535, r);
              default: run_case(blk, b, w, r, 8191, -8191, 7, 0, r);
            endcase
          end
    run_err(8, 1, -8192, 0);
    run_err(8, 1, 0, -65536);
    run_err(0, 1, 0, 0);
    run_err(8, 0, 0, 0);
    run_case(10, 1, 2, 1, -8191, 8191, 65535, -65535, 1);   // R3 short last burst
    run_case(4, 1, 2, 2047, 0, 0, 12, -4, 0);               // R6 2048 blocks
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule